// File: doc/BRIEF.md
# Station-address PROM access decoder

This block sits at the host side of a network controller's register window and decides, for each host access, whether it reaches a 16-byte station-address PROM, goes on to the controller's register port, or is refused. One request channel carries both front ends. A space bit selects between them. The I/O front end sends offsets below 0x10 to the PROM. On that front end, the legal access sizes depend on a word/doubleword I/O mode bit. The memory-mapped front end uses address bit 4 alone to pick the PROM half or the register half.

Accesses to the PROM are assembled little-endian from single bytes, and writes are split into bytes. A PROM write lands only while a write-enable bit is set. At reset the PROM loads a default station address plus padding from a parameter, and both mode bits clear. The two mode bits are loaded through a small configuration strobe. A read returns its data one cycle after the request, together with a valid strobe. Read data from the register port is passed back to the host unchanged.

Top module: `prom_access_decoder`

## Requirements
- R1: After reset, the PROM holds the bytes of the PROM_INIT parameter (byte i in bits 8i+7:8i), rvalid_o is low, and both the doubleword mode and the PROM write-enable are clear.
- R2: On the I/O front end (mem_space_i=0), offsets 0x00–0x0F address the PROM byte given by addr_i[3:0]. Offsets 0x10 and above are forwarded to the register port. A forwarded request asserts reg_req_o in the request cycle and carries reg_offs_o=addr_i[3:0], reg_size_o=size_i, reg_we_o=we_i and reg_wdata_o=wdata_i.
- R3: With doubleword mode clear, I/O PROM accesses are legal in two cases only: size code 0 (1 byte) at any offset, and size code 1 (2 bytes) at even offsets.
- R4: With doubleword mode set, the only legal I/O PROM access is size code 2 (4 bytes) at an offset that is a multiple of 4.
- R5: An illegal read returns ones across the requested width, with zeros above it: 0xFF for code 0, 0xFFFF for code 1, and 0xFFFFFFFF for codes 2 and 3. An illegal write changes nothing and raises no reg_req_o.
- R6: PROM bytes are written only while the PROM write-enable is set. PROM reads work whatever its value.
- R7: Multi-byte PROM accesses are little-endian. The byte at the access offset is in bits 7:0 and each following byte is in the next lane up. Single-byte reads return zero in bits 31:8.
- R8: On the memory-mapped front end (mem_space_i=1), addr_i[4]=0 selects the PROM with the offset taken from addr_i[3:0]. Any of size codes 0, 1 and 2 is legal there at any offset, the byte index wraps modulo 16, and the doubleword mode has no effect.
- R9: On the register half of either front end, only size codes 1 and 2 are forwarded. Other sizes read as ones (R5), and writes of other sizes are dropped with no reg_req_o.
- R10: rvalid_o pulses exactly one cycle after each read request and never after a write. For a forwarded read, rdata_o equals the reg_rdata_i value seen in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Loads the two mode bits below |
| cfg_dword_i | input | 1 | New doubleword I/O mode value |
| cfg_prom_we_i | input | 1 | New PROM write-enable value |
| req_i | input | 1 | Host access request |
| mem_space_i | input | 1 | 0 = I/O front end, 1 = memory-mapped front end |
| addr_i | input | AW | Byte offset within the window |
| size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| we_i | input | 1 | Write when set, read when clear |
| wdata_i | input | 32 | Write data, lowest byte in bits 7:0 |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe |
| reg_req_o | output | 1 | Register port request |
| reg_we_o | output | 1 | Register port write flag |
| reg_offs_o | output | 4 | Register port offset |
| reg_size_o | output | 2 | Register port size code |
| reg_wdata_o | output | 32 | Register port write data |
| reg_rdata_i | input | 32 | Register port read data |

## Verification
The hardest case to reach is a PROM write that must be shown to have had no effect. There are three such cases: writes with the write-enable clear, misaligned or wrong-size I/O writes, and byte writes to the register half. None of them shows up on any output in the cycle it happens. The bench keeps its own copy of the PROM, so every such write is later exposed by reads. It toggles the write-enable and the doubleword mode between random bursts that mix both front ends, every offset and every size code. It then closes with a full sweep that reads back all 16 bytes. Directed cases add the wrap-around word read at offset 0x0E on the memory front end and size code 3.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int HOST_DW    = 32;
  localparam int LANES      = HOST_DW / 8;
  localparam int PROM_BYTES = 16;
  localparam int PIW        = $clog2(PROM_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef struct packed {
    logic             prom;
    logic             regp;
    logic [LANES-1:0] lanes;
    logic [PIW-1:0]   base;
  } route_t;

  function automatic logic [HOST_DW-1:0] ones_for(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: ones_for = HOST_DW'(8'hFF);
      SZ_HALF: ones_for = HOST_DW'(16'hFFFF);
      default: ones_for = '1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lanes_for(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lanes_for = LANES'(4'b0001);
      SZ_HALF: lanes_for = LANES'(4'b0011);
      default: lanes_for = '1;
    endcase
  endfunction
endpackage

// File: rtl/pad_route.sv
module pad_route
  import pad_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          mem_space_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          dword_i,
  output route_t        route_o
);
  logic low_half;
  logic reg_size_ok;

  // I/O: whole offset below 0x10; memory: only bit 4 decides
  assign low_half    = mem_space_i ? ~addr_i[4] : ~(|addr_i[AW-1:4]);
  assign reg_size_ok = (size_i == SZ_HALF) || (size_i == SZ_WORD);

  always_comb begin
    route_o       = '0;
    route_o.base  = addr_i[PIW-1:0];
    route_o.lanes = lanes_for(size_i);
    if (!low_half) begin
      route_o.regp = reg_size_ok;
    end else if (mem_space_i) begin
      route_o.prom = (size_i != SZ_BAD);
    end else if (!dword_i) begin
      route_o.prom = (size_i == SZ_BYTE) || (size_i == SZ_HALF && !addr_i[0]);
    end else begin
      route_o.prom = (size_i == SZ_WORD) && (addr_i[1:0] == 2'b00);
    end
  end
endmodule

// File: rtl/pad_prom_store.sv
module pad_prom_store
  import pad_pkg::*;
#(
  parameter logic [8*PROM_BYTES-1:0] INIT = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [LANES-1:0]   lanes_i,
  input  logic [PIW-1:0]     base_i,
  input  logic [HOST_DW-1:0] wdata_i,
  output logic [HOST_DW-1:0] rdata_o
);
  logic [8*PROM_BYTES-1:0] flat;

  for (genvar i = 0; i < PROM_BYTES; i++) begin : g_byte
    logic [7:0] byte_q;
    logic       hit;
    logic [7:0] nxt;

    always_comb begin
      hit = 1'b0;
      nxt = byte_q;
      for (int k = 0; k < LANES; k++) begin
        if (wr_en_i && lanes_i[k] && (PIW'(base_i + PIW'(k)) == PIW'(i))) begin
          hit = 1'b1;
          nxt = wdata_i[8*k +: 8];
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  byte_q <= INIT[8*i +: 8];
      else if (hit) byte_q <= nxt;
    end

    assign flat[8*i +: 8] = byte_q;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PIW-1:0] idx;
    assign idx = PIW'(base_i + PIW'(k));
    assign rdata_o[8*k +: 8] = lanes_i[k] ? flat[8*idx +: 8] : 8'h00;
  end
endmodule

// File: rtl/pad_resp.sv
module pad_resp
  import pad_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               prom_i,
  input  logic               regp_i,
  input  logic [1:0]         size_i,
  input  logic [HOST_DW-1:0] prom_rdata_i,
  input  logic [HOST_DW-1:0] reg_rdata_i,
  output logic [HOST_DW-1:0] rdata_o,
  output logic               rvalid_o
);
  logic [HOST_DW-1:0] sel;

  always_comb begin
    if (prom_i)      sel = prom_rdata_i;
    else if (regp_i) sel = reg_rdata_i;
    else             sel = ones_for(size_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= sel;
    end
  end
endmodule

// File: rtl/prom_access_decoder.sv
module prom_access_decoder
  import pad_pkg::*;
#(
  parameter int AW = 5,
  parameter logic [8*PROM_BYTES-1:0] PROM_INIT = 128'h5757_0000_0000_0000_0000_5634_1200_5452
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_dword_i,
  input  logic               cfg_prom_we_i,
  input  logic               req_i,
  input  logic               mem_space_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [1:0]         size_i,
  input  logic               we_i,
  input  logic [HOST_DW-1:0] wdata_i,
  output logic [HOST_DW-1:0] rdata_o,
  output logic               rvalid_o,
  output logic               reg_req_o,
  output logic               reg_we_o,
  output logic [3:0]         reg_offs_o,
  output logic [1:0]         reg_size_o,
  output logic [HOST_DW-1:0] reg_wdata_o,
  input  logic [HOST_DW-1:0] reg_rdata_i
);
  logic               dword_q;
  logic               prom_we_q;
  route_t             route;
  logic [HOST_DW-1:0] prom_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dword_q   <= 1'b0;
      prom_we_q <= 1'b0;
    end else if (cfg_we_i) begin
      dword_q   <= cfg_dword_i;
      prom_we_q <= cfg_prom_we_i;
    end
  end

  pad_route #(.AW(AW)) u_route (
    .mem_space_i(mem_space_i),
    .addr_i     (addr_i),
    .size_i     (size_i),
    .dword_i    (dword_q),
    .route_o    (route)
  );

  pad_prom_store #(.INIT(PROM_INIT)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(req_i && we_i && route.prom && prom_we_q),
    .lanes_i(route.lanes),
    .base_i (route.base),
    .wdata_i(wdata_i),
    .rdata_o(prom_rdata)
  );

  pad_resp u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (req_i && !we_i),
    .prom_i      (route.prom),
    .regp_i      (route.regp),
    .size_i      (size_i),
    .prom_rdata_i(prom_rdata),
    .reg_rdata_i (reg_rdata_i),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );

  assign reg_req_o   = req_i && route.regp;
  assign reg_we_o    = we_i;
  assign reg_offs_o  = addr_i[3:0];
  assign reg_size_o  = size_i;
  assign reg_wdata_o = wdata_i;
endmodule

// File: rtl/pad_checker.sv
module pad_checker #(
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          mem_space_i,
  input logic [AW-1:0] addr_i,
  input logic [1:0]    size_i,
  input logic          we_i,
  input logic [31:0]   rdata_o,
  input logic          rvalid_o,
  input logic          reg_req_o,
  input logic [3:0]    reg_offs_o,
  input logic [1:0]    reg_size_o,
  input logic [31:0]   reg_rdata_i
);
  p_rvalid_after_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_no_rvalid_otherwise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  p_reg_data_passthru_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && !we_i) |=> (rdata_o == $past(reg_rdata_i)));

  p_reg_only_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> (req_i && (mem_space_i ? addr_i[4] : (|addr_i[AW-1:4]))));

  p_reg_fields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> (reg_offs_o == addr_i[3:0] && reg_size_o == size_i));

  p_reg_no_byte_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd0 || size_i == 2'd3) |-> !reg_req_o);

  p_byte_read_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd0) |=> (rdata_o[31:8] == 24'h0));
endmodule

bind prom_access_decoder pad_checker #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .mem_space_i(mem_space_i),
  .addr_i     (addr_i),
  .size_i     (size_i),
  .we_i       (we_i),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o),
  .reg_req_o  (reg_req_o),
  .reg_offs_o (reg_offs_o),
  .reg_size_o (reg_size_o),
  .reg_rdata_i(reg_rdata_i)
);

// File: tb/prom_access_decoder_test.sv
`timescale 1ns/1ps
module prom_access_decoder_test;
  localparam logic [127:0] INIT = 128'h5757_0000_0000_0000_0000_5634_1200_5452;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_dword = 1'b0, cfg_pwe = 1'b0;
  logic        req = 1'b0, mem = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, reg_wdata, reg_rdata;
  logic        rvalid, reg_req, reg_we;
  logic [3:0]  reg_offs;
  logic [1:0]  reg_size;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [16];
  bit m_dword = 0, m_pwe = 0;

  always #10 clk = ~clk;

  assign reg_rdata = {16'hC0DE, 12'h000, reg_offs};

  prom_access_decoder uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_dword_i(cfg_dword), .cfg_prom_we_i(cfg_pwe),
    .req_i(req), .mem_space_i(mem), .addr_i(addr), .size_i(size), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_offs_o(reg_offs),
    .reg_size_o(reg_size), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 = refused, 1 = PROM, 2 = register port
  function automatic int kind_of(bit m, logic [4:0] a, logic [1:0] sz, bit dw);
    if (!a[4]) begin
      if (m) return (sz != 2'd3) ? 1 : 0;
      if (!dw) return (sz == 2'd0 || (sz == 2'd1 && !a[0])) ? 1 : 0;
      return (sz == 2'd2 && a[1:0] == 2'b00) ? 1 : 0;
    end
    return (sz == 2'd1 || sz == 2'd2) ? 2 : 0;
  endfunction

  function automatic int nbytes(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ones(logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] prom_word(logic [3:0] b, logic [1:0] sz);
    logic [31:0] v = '0;
    for (int k = 0; k < nbytes(sz); k++) v[8*k +: 8] = model[4'(b + 4'(k))];
    return v;
  endfunction

  task automatic set_cfg(bit dw, bit pwe);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dword = dw; cfg_pwe = pwe;
    @(negedge clk);
    cfg_we = 1'b0;
    m_dword = dw; m_pwe = pwe;
  endtask

  task automatic access(bit m, logic [4:0] a, logic [1:0] sz, bit w, logic [31:0] d, string tag);
    int k_ = kind_of(m, a, sz, m_dword);
    logic [31:0] exp;
    @(negedge clk);
    req = 1'b1; mem = m; addr = a; size = sz; we = w; wdata = d;
    #1;
    chk(reg_req == (k_ == 2), {tag, " reg_req"}, 32'(reg_req), 32'(k_ == 2));
    if (k_ == 2)
      chk(reg_offs == a[3:0] && reg_size == sz && reg_we == w && reg_wdata == d,
          {tag, " R2 fields"}, {reg_offs, reg_size, 25'(reg_we)}, {a[3:0], sz, 25'(w)});
    if (k_ == 1) exp = prom_word(a[3:0], sz);
    else if (k_ == 2) exp = {16'hC0DE, 12'h000, a[3:0]};
    else exp = ones(sz);
    @(negedge clk);
    req = 1'b0;
    chk(rvalid == !w, {tag, " R10 rvalid"}, 32'(rvalid), 32'(!w));
    if (!w) chk(rdata == exp, {tag, " rdata"}, rdata, exp);
    if (w && k_ == 1 && m_pwe)
      for (int k = 0; k < nbytes(sz); k++) model[4'(a[3:0] + 4'(k))] = d[8*k +: 8];
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 16; i++) access(1'b1, 5'(i), 2'd0, 1'b0, '0, tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) model[i] = INIT[8*i +: 8];
    #35 rst_n = 1'b1;
    @(negedge clk);
    chk(rvalid == 1'b0, "R1 rvalid", 32'(rvalid), 0);
    sweep("R1 init");
    // R1/R6: write-enable clear after reset, writes must not land
    access(1'b0, 5'h02, 2'd1, 1'b1, 32'h0000_BBAA, "R6 pwe off");
    access(1'b0, 5'h02, 2'd1, 1'b0, '0, "R6 read back");
    // R3 word mode legal/illegal
    access(1'b0, 5'h03, 2'd0, 1'b0, '0, "R3 byte odd");
    access(1'b0, 5'h04, 2'd1, 1'b0, '0, "R3 half even");
    access(1'b0, 5'h05, 2'd1, 1'b0, '0, "R5 half odd");
    access(1'b0, 5'h04, 2'd2, 1'b0, '0, "R5 word wmode");
    set_cfg(1'b0, 1'b1);
    access(1'b0, 5'h07, 2'd1, 1'b1, 32'h0000_1111, "R5 odd wr");
    access(1'b0, 5'h06, 2'd1, 1'b1, 32'h0000_2233, "R6 pwe on");
    access(1'b0, 5'h06, 2'd1, 1'b0, '0, "R7 half");
    // R4 doubleword mode
    set_cfg(1'b1, 1'b1);
    access(1'b0, 5'h08, 2'd2, 1'b1, 32'hDDCC_BBAA, "R4 word wr");
    access(1'b0, 5'h08, 2'd2, 1'b0, '0, "R7 word");
    access(1'b0, 5'h02, 2'd0, 1'b0, '0, "R4 byte illegal");
    access(1'b0, 5'h02, 2'd1, 1'b1, 32'h0000_9999, "R4 half wr illegal");
    access(1'b0, 5'h0A, 2'd2, 1'b0, '0, "R4 word misaligned");
    // R8 memory front end ignores mode, wraps
    access(1'b1, 5'h0E, 2'd2, 1'b0, '0, "R8 wrap read");
    access(1'b1, 5'h0D, 2'd2, 1'b1, 32'h4433_2211, "R8 wrap write");
    access(1'b1, 5'h03, 2'd3, 1'b0, '0, "R5 size3");
    // R9 register half
    access(1'b1, 5'h12, 2'd0, 1'b0, '0, "R9 mem byte");
    access(1'b1, 5'h12, 2'd0, 1'b1, 32'h55, "R9 mem byte wr");
    access(1'b0, 5'h1C, 2'd2, 1'b0, '0, "R2 io word");
    access(1'b1, 5'h14, 2'd1, 1'b1, 32'h1234, "R2 mem half wr");
    sweep("R8 sweep");
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) set_cfg(1'($urandom), 1'($urandom));
      access(1'($urandom), 5'($urandom), 2'($urandom), ($urandom % 3) == 0, $urandom,
             "R5 R7 rand");
    end
    sweep("R6 final");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule